// File: doc/BRIEF.md
# Seeded Local-Alignment Extension Array

This block scores how far an exact seed match between a short read and a reference window can be extended by an alignment that allows gaps. The caller loads the read, the reference window, a non-zero seed score and four scoring weights, then pulses `start`. Both sequences are 2-bit coded. A row of `PES` processing elements walks the score matrix one anti-diagonal per step. Each element owns one read symbol, so one matrix row, for the length of a pass. Reference symbols and partial results move one element down the row on each step. A read longer than the array is handled in more than one pass. The last element writes the bottom row of each pass into a border store. The first element of the next pass reads that row back as its upper neighbour.

The block reports two results. The first is the best cell anywhere in the matrix with its row and column. The second is the best cell in the final read row (the whole read consumed) with its column. Matrix edges start from the seed score, not from zero. The scheduler never clocks a step in which every element of the pass would be idle, so a short final pass is shorter. The control is a five-state machine:
- IDLE waits for `start`.
- PREP clears the per-row maxima and preloads the feed for column 1.
- STEP advances the wavefront.
- MERGE visits the element row maxima in row order.
- FIN raises `done`.

The transitions are:
- IDLE→PREP on `start`.
- PREP→STEP always.
- STEP→MERGE after the last useful step.
- MERGE→PREP when read rows remain.
- MERGE→FIN after the last row.
- FIN→IDLE always.

Top module: `seed_ext_array`

## Requirements
- R1: After reset, `busy`, `done`, `best_score`, `best_row`, `best_col`, `end_score` and `end_col` are all zero.
- R2: Symbols are coded A=00, C=01, G=10, T=11. Read symbol k (row k+1) sits in `read_syms[2k+1:2k]` and reference symbol k (column k+1) in `ref_syms[2k+1:2k]`. For i,j ≥ 1, the cell scores are:
  - E(i,j) = max(0, H(i,j-1)-open-ext, E(i,j-1)-ext)
  - F(i,j) = max(0, H(i-1,j)-open-ext, F(i-1,j)-ext)
  - H(i,j) = max(0, H(i-1,j-1)±w, E, F), where w is `match_bonus` on equal symbols and `mismatch_pen` otherwise.
  - E on column 0 and F on row 0 are zero.
- R3: H(0,0) equals the seed. Every other row-0 or column-0 cell at distance x from the corner is max(0, seed-open-x·ext). The global result starts as the seed at row 0, column 0.
- R4: Reads longer than `PES` symbols give the same results as one large array. The bottom row of each pass, both H and F, is replayed into the next pass.
- R5: `best_score` is the largest H over all cells, or the seed if it is larger. `best_row`/`best_col` locate the first cell holding it in row-major order. A tie with the seed keeps row 0, column 0.
- R6: `end_score` is the largest H in the final read row. `end_col` is the smallest column holding it, and both are 0 when that row is all zero.
- R7: `done` is high for exactly one cycle per job, in the last cycle `busy` is high, and the outputs are valid from then on.
- R8: Idle steps are skipped. A job keeps `busy` high for 1 + Σ over passes of (ref_len + 2·rows_in_pass) cycles, where rows_in_pass is min(`PES`, remaining rows).
- R9: All inputs are captured on the accepted `start`. A `start` or an input change while busy has no effect on the result, the cycle count or the number of `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job (accepted when idle) |
| read_len | input | 7 | Read length, 1..MAX_READ |
| ref_len | input | 7 | Reference window length, 1..MAX_REF |
| read_syms | input | 128 | Packed 2-bit read symbols |
| ref_syms | input | 128 | Packed 2-bit reference symbols |
| seed_score | input | 14 | Non-negative seed score |
| match_bonus | input | 8 | Added on equal symbols |
| mismatch_pen | input | 8 | Subtracted on unequal symbols |
| gap_open | input | 8 | Gap opening penalty |
| gap_ext | input | 8 | Per-symbol gap penalty |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| best_score | output | 16 | Global maximum score |
| best_row | output | 7 | Row of the global maximum |
| best_col | output | 7 | Column of the global maximum |
| end_score | output | 16 | Maximum of the final read row |
| end_col | output | 7 | Column of the final-row maximum |

## Verification
When the best cell lies in the final read row, one MERGE cycle both replaces the global maximum and captures the end-row result from the same element entry. Exact-match and tie jobs put the peak on the last row to provoke this. They are judged by requiring both result pairs to name the same column and score as an independent matrix model. In a multi-pass job, the delayed border write of a pass's last step lands in the first MERGE cycle. The next pass's first border read then follows in PREP. The 64-symbol and 33-symbol reads check that the replayed row was not overtaken.

// File: rtl/sx_pkg.sv
package sx_pkg;

    localparam int SCORE_W = 16;
    localparam int PEN_W   = 8;

    typedef logic signed [SCORE_W-1:0] score_t;
    typedef logic [PEN_W-1:0]          pen_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PREP,
        S_STEP,
        S_MERGE,
        S_FIN
    } sx_state_t;

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // Border value at distance x from the seeded corner.
    function automatic score_t edge_init(score_t seed, pen_t gopen, pen_t gext,
                                         logic [15:0] x);
        int v;
        if (x == 16'd0) return seed;
        v = int'(seed) - int'(gopen) - int'(x) * int'(gext);
        return (v < 0) ? '0 : score_t'(v);
    endfunction

endpackage

// File: rtl/sx_border_buf.sv
module sx_border_buf #(
    parameter int DEPTH = 64,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/sx_pe.sv
module sx_pe
    import sx_pkg::*;
#(
    parameter int IDX = 0,
    parameter int STW = 7,
    parameter int CLW = 7,
    parameter int RW  = 7,
    parameter int KW  = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           step,
    input  logic [STW-1:0] t,
    input  logic [CLW-1:0] ref_len,
    input  logic [KW-1:0]  nrows,
    input  logic [RW-1:0]  row,
    input  logic [1:0]     rd_sym,
    input  score_t         seed,
    input  pen_t           mb,
    input  pen_t           mm,
    input  pen_t           go,
    input  pen_t           ge,
    input  score_t         up_h,
    input  score_t         up_f,
    input  logic [1:0]     up_c,
    output score_t         h_o,
    output score_t         f_o,
    output logic [1:0]     c_o,
    output logic           act,
    output score_t         rmax,
    output logic [CLW-1:0] rcol
);

    logic [STW-1:0] rel;
    logic           first;
    logic [CLW-1:0] col;
    score_t         e_r;
    score_t         diag_r;
    int             lh, le, dg, sc, e_n, f_n, h_n;

    always_comb begin
        rel   = t - STW'(IDX);
        act   = (t >= STW'(IDX)) && (rel < STW'(ref_len)) && (KW'(IDX) < nrows);
        first = (rel == '0);
        col   = CLW'(rel + 1'b1);
        lh    = first ? int'(edge_init(seed, go, ge, 16'(row))) : int'(h_o);
        le    = first ? 0 : int'(e_r);
        dg    = first ? int'(edge_init(seed, go, ge, 16'(row - 1'b1))) : int'(diag_r);
        sc    = (rd_sym == up_c) ? int'(mb) : -int'(mm);
        e_n   = imax(0, imax(lh - int'(go) - int'(ge), le - int'(ge)));
        f_n   = imax(0, imax(int'(up_h) - int'(go) - int'(ge), int'(up_f) - int'(ge)));
        h_n   = imax(imax(0, dg + sc), imax(e_n, f_n));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_o    <= '0;
            f_o    <= '0;
            c_o    <= '0;
            e_r    <= '0;
            diag_r <= '0;
            rmax   <= '0;
            rcol   <= '0;
        end else if (clr) begin
            rmax <= '0;
            rcol <= '0;
        end else if (step) begin
            diag_r <= up_h;
            if (act) begin
                h_o <= score_t'(h_n);
                f_o <= score_t'(f_n);
                e_r <= score_t'(e_n);
                c_o <= up_c;
                if (h_n > int'(rmax)) begin
                    rmax <= score_t'(h_n);
                    rcol <= col;
                end
            end
        end
    end

    // R2
    h_dominates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && act) |=> (h_o >= f_o && h_o >= e_r));

    // R6
    rowmax_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (rmax >= $past(rmax)));

endmodule

// File: rtl/seed_ext_array.sv
module seed_ext_array
    import sx_pkg::*;
#(
    parameter int PES      = 32,
    parameter int MAX_READ = 64,
    parameter int MAX_REF  = 64,
    localparam int RW    = $clog2(MAX_READ + 1),
    localparam int CLW   = $clog2(MAX_REF + 1),
    localparam int SEEDW = SCORE_W - 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [RW-1:0]         read_len,
    input  logic [CLW-1:0]        ref_len,
    input  logic [2*MAX_READ-1:0] read_syms,
    input  logic [2*MAX_REF-1:0]  ref_syms,
    input  logic [SEEDW-1:0]      seed_score,
    input  logic [PEN_W-1:0]      match_bonus,
    input  logic [PEN_W-1:0]      mismatch_pen,
    input  logic [PEN_W-1:0]      gap_open,
    input  logic [PEN_W-1:0]      gap_ext,
    output logic                  busy,
    output logic                  done,
    output logic [SCORE_W-1:0]    best_score,
    output logic [RW-1:0]         best_row,
    output logic [CLW-1:0]        best_col,
    output logic [SCORE_W-1:0]    end_score,
    output logic [CLW-1:0]        end_col
);

    localparam int STW = $clog2(MAX_REF + PES + 1);
    localparam int KW  = $clog2(PES + 1);
    localparam int PW  = (PES > 1) ? $clog2(PES) : 1;
    localparam int AW  = $clog2(MAX_REF);
    localparam int BW  = 2 * SCORE_W;

    sx_state_t state, nxt;

    logic [2*MAX_READ-1:0] rd_q;
    logic [2*MAX_REF-1:0]  rf_q;
    logic [RW-1:0]         nlen_q;
    logic [CLW-1:0]        mlen_q;
    score_t                seed_q;
    pen_t                  mb_q, mm_q, go_q, ge_q;
    logic [RW-1:0]         r0_q;
    logic                  first_pass_q;
    logic [STW-1:0]        t_q;
    logic [PW-1:0]         m_q;

    score_t                best_q, end_q;
    logic [RW-1:0]         brow_q;
    logic [CLW-1:0]        bcol_q, ecol_q;

    score_t                fd_h, fd_f;
    logic [1:0]            fd_c;

    score_t                pe_h    [PES];
    score_t                pe_f    [PES];
    logic [1:0]            pe_c    [PES];
    score_t                pe_rmax [PES];
    logic [CLW-1:0]        pe_rcol [PES];
    logic [PES-1:0]        pe_act;

    logic [KW-1:0]         k_rows;
    logic [STW-1:0]        t_last;
    logic                  last_m, final_pass;
    score_t                mv;
    logic [CLW-1:0]        mc;
    logic [RW-1:0]         mrow;

    logic                  wr_q;
    logic [AW-1:0]         wr_addr_q;
    logic [AW-1:0]         buf_raddr;
    logic [BW-1:0]         buf_rdata;
    score_t                fd_h_n, fd_f_n;
    logic [1:0]            fd_c_n;

    // ---------------- pass bookkeeping (combinational) ----------------
    always_comb begin
        int rem;
        rem        = int'(nlen_q) - int'(r0_q) + 1;
        k_rows     = (rem > PES) ? KW'(PES) : KW'(rem);
        t_last     = STW'(int'(mlen_q) + int'(k_rows) - 2);
        last_m     = (int'(m_q) == int'(k_rows) - 1);
        final_pass = (int'(r0_q) + int'(k_rows) - 1 == int'(nlen_q));
        mv         = pe_rmax[m_q];
        mc         = pe_rcol[m_q];
        mrow       = RW'(int'(r0_q) + int'(m_q));
    end

    // ---------------- feed for the first element ----------------
    always_comb begin
        int jl;
        jl        = (state == S_PREP) ? 1 : int'(t_q) + 2;
        fd_c_n    = (jl <= MAX_REF) ? rf_q[2*(jl-1) +: 2] : 2'b00;
        buf_raddr = (jl <= MAX_REF) ? AW'(jl - 1) : '0;
        fd_h_n    = first_pass_q ? edge_init(seed_q, go_q, ge_q, 16'(jl))
                                 : score_t'(buf_rdata[BW-1:SCORE_W]);
        fd_f_n    = first_pass_q ? '0 : score_t'(buf_rdata[SCORE_W-1:0]);
    end

    sx_border_buf #(.DEPTH(MAX_REF), .W(BW)) u_border (
        .clk   (clk),
        .we    (wr_q),
        .waddr (wr_addr_q),
        .wdata ({pe_h[PES-1], pe_f[PES-1]}),
        .raddr (buf_raddr),
        .rdata (buf_rdata)
    );

    // ---------------- element row ----------------
    for (genvar q = 0; q < PES; q++) begin : g_pe
        logic [1:0] rs;
        score_t     uh, uf;
        logic [1:0] uc;

        always_comb begin
            int ri;
            ri = int'(r0_q) - 1 + q;
            rs = (ri < MAX_READ) ? rd_q[2*ri +: 2] : 2'b00;
        end

        if (q == 0) begin : g_head
            assign uh = fd_h;
            assign uf = fd_f;
            assign uc = fd_c;
        end else begin : g_body
            assign uh = pe_h[q-1];
            assign uf = pe_f[q-1];
            assign uc = pe_c[q-1];
        end

        sx_pe #(.IDX(q), .STW(STW), .CLW(CLW), .RW(RW), .KW(KW)) u_pe (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (state == S_PREP),
            .step    (state == S_STEP),
            .t       (t_q),
            .ref_len (mlen_q),
            .nrows   (k_rows),
            .row     (RW'(int'(r0_q) + q)),
            .rd_sym  (rs),
            .seed    (seed_q),
            .mb      (mb_q),
            .mm      (mm_q),
            .go      (go_q),
            .ge      (ge_q),
            .up_h    (uh),
            .up_f    (uf),
            .up_c    (uc),
            .h_o     (pe_h[q]),
            .f_o     (pe_f[q]),
            .c_o     (pe_c[q]),
            .act     (pe_act[q]),
            .rmax    (pe_rmax[q]),
            .rcol    (pe_rcol[q])
        );
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = S_PREP;
            S_PREP:  nxt = S_STEP;
            S_STEP:  if (t_q == t_last) nxt = S_MERGE;
            S_MERGE: if (last_m) nxt = final_pass ? S_FIN : S_PREP;
            S_FIN:   nxt = S_IDLE;
        endcase
    end

    // ---------------- datapath and outputs ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0; rf_q <= '0; nlen_q <= '0; mlen_q <= '0;
            seed_q <= '0; mb_q <= '0; mm_q <= '0; go_q <= '0; ge_q <= '0;
            r0_q <= '0; first_pass_q <= 1'b1; t_q <= '0; m_q <= '0;
            best_q <= '0; brow_q <= '0; bcol_q <= '0; end_q <= '0; ecol_q <= '0;
            fd_h <= '0; fd_f <= '0; fd_c <= '0;
            wr_q <= 1'b0; wr_addr_q <= '0;
        end else begin
            wr_q      <= (state == S_STEP) && pe_act[PES-1];
            wr_addr_q <= AW'(t_q - STW'(PES - 1));
            unique case (state)
                S_IDLE: if (start) begin
                    rd_q <= read_syms; rf_q <= ref_syms;
                    nlen_q <= read_len; mlen_q <= ref_len;
                    seed_q <= score_t'(seed_score);
                    mb_q <= match_bonus; mm_q <= mismatch_pen;
                    go_q <= gap_open; ge_q <= gap_ext;
                    r0_q <= RW'(1); first_pass_q <= 1'b1;
                    best_q <= score_t'(seed_score); brow_q <= '0; bcol_q <= '0;
                    end_q <= '0; ecol_q <= '0;
                end
                S_PREP: begin
                    t_q <= '0; m_q <= '0;
                    fd_h <= fd_h_n; fd_f <= fd_f_n; fd_c <= fd_c_n;
                end
                S_STEP: begin
                    t_q <= t_q + 1'b1;
                    fd_h <= fd_h_n; fd_f <= fd_f_n; fd_c <= fd_c_n;
                end
                S_MERGE: begin
                    m_q <= m_q + 1'b1;
                    if (mv > best_q) begin
                        best_q <= mv; brow_q <= mrow; bcol_q <= mc;
                    end
                    if (mrow == nlen_q) begin
                        end_q <= mv; ecol_q <= mc;
                    end
                    if (last_m && !final_pass) begin
                        r0_q <= RW'(int'(r0_q) + PES);
                        first_pass_q <= 1'b0;
                    end
                end
                S_FIN: ;
            endcase
        end
    end

    assign busy       = (state != S_IDLE);
    assign done       = (state == S_FIN);
    assign best_score = best_q;
    assign best_row   = brow_q;
    assign best_col   = bcol_q;
    assign end_score  = end_q;
    assign end_col    = ecol_q;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);

    // R4
    border_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q |-> (int'(wr_addr_q) < int'(mlen_q)));

    // R3
    best_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state != S_PREP) |-> (best_q >= seed_q));

endmodule

// File: tb/test_seed_ext_array.sv
`timescale 1ns/1ps
module test_seed_ext_array;

    localparam int MAXR = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [6:0]   read_len = '0;
    logic [6:0]   ref_len = '0;
    logic [127:0] read_syms = '0;
    logic [127:0] ref_syms = '0;
    logic [13:0]  seed_score = '0;
    logic [7:0]   match_bonus = '0, mismatch_pen = '0, gap_open = '0, gap_ext = '0;
    logic         busy, done;
    logic [15:0]  best_score, end_score;
    logic [6:0]   best_row, best_col, end_col;

    int checks = 0;
    int errors = 0;

    int rd [MAXR];
    int rf [MAXR];
    int H  [0:MAXR][0:MAXR];
    int E  [0:MAXR][0:MAXR];
    int F  [0:MAXR][0:MAXR];
    int xb, xr, xc, xe, xec;

    always #10 clk = ~clk;

    seed_ext_array i_seed_ext_array (
        .clk(clk), .rst_n(rst_n), .start(start),
        .read_len(read_len), .ref_len(ref_len),
        .read_syms(read_syms), .ref_syms(ref_syms),
        .seed_score(seed_score), .match_bonus(match_bonus),
        .mismatch_pen(mismatch_pen), .gap_open(gap_open), .gap_ext(gap_ext),
        .busy(busy), .done(done),
        .best_score(best_score), .best_row(best_row), .best_col(best_col),
        .end_score(end_score), .end_col(end_col)
    );

    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model(int n, int m, int sd, int mb, int mm, int go, int ge);
        for (int i = 0; i <= n; i++) begin
            H[i][0] = (i == 0) ? sd : mx(0, sd - go - i * ge);
            E[i][0] = 0;
        end
        for (int j = 1; j <= m; j++) begin
            H[0][j] = mx(0, sd - go - j * ge);
            F[0][j] = 0;
        end
        xb = sd; xr = 0; xc = 0;
        for (int i = 1; i <= n; i++) begin
            for (int j = 1; j <= m; j++) begin
                int s;
                E[i][j] = mx(0, mx(H[i][j-1] - go - ge, E[i][j-1] - ge));
                F[i][j] = mx(0, mx(H[i-1][j] - go - ge, F[i-1][j] - ge));
                s = (rd[i-1] == rf[j-1]) ? mb : -mm;
                H[i][j] = mx(mx(0, H[i-1][j-1] + s), mx(E[i][j], F[i][j]));
                if (H[i][j] > xb) begin xb = H[i][j]; xr = i; xc = j; end
            end
        end
        xe = 0; xec = 0;
        for (int j = 1; j <= m; j++)
            if (H[n][j] > xe) begin xe = H[n][j]; xec = j; end
    endtask

    // Runs one job; tag names the requirement the result checks belong to.
    task automatic run_job(string tag, int n, int m, int sd, int mb, int mm,
                           int go, int ge, bit disturb);
        int busy_cnt, done_cnt, cyc, exp_cyc;
        model(n, m, sd, mb, mm, go, ge);
        exp_cyc = 1;
        for (int r = 0; r < n; r += 32) exp_cyc += m + 2 * ((n - r > 32) ? 32 : (n - r));
        @(negedge clk);
        read_syms = '0; ref_syms = '0;
        for (int k = 0; k < n; k++) read_syms[2*k +: 2] = 2'(rd[k]);
        for (int k = 0; k < m; k++) ref_syms[2*k +: 2] = 2'(rf[k]);
        read_len = 7'(n); ref_len = 7'(m); seed_score = 14'(sd);
        match_bonus = 8'(mb); mismatch_pen = 8'(mm); gap_open = 8'(go); gap_ext = 8'(ge);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        busy_cnt = 0; done_cnt = 0; cyc = 0;
        while (busy && cyc < 20000) begin
            busy_cnt++;
            if (done) done_cnt++;
            if (disturb && cyc == 5) begin
                start = 1'b1; read_syms = ~read_syms; ref_syms = ~ref_syms;
                seed_score = 14'd3; match_bonus = 8'd9; gap_ext = 8'd0;
                read_len = 7'd3; ref_len = 7'd2;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk("R7", "watchdog", (cyc >= 20000) ? 1 : 0, 0);
        chk(tag, "best_score", int'(best_score), xb);
        chk(tag, "best_row", int'(best_row), xr);
        chk(tag, "best_col", int'(best_col), xc);
        chk("R6", "end_score", int'(end_score), xe);
        chk("R6", "end_col", int'(end_col), xec);
        chk("R8", "busy_cycles", busy_cnt, exp_cyc);
        chk("R7", "done_pulses", done_cnt, 1);
    endtask

    task automatic t_reset();
        // R1
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "best_score", int'(best_score), 0);
        chk("R1", "best_row", int'(best_row), 0);
        chk("R1", "best_col", int'(best_col), 0);
        chk("R1", "end_score", int'(end_score), 0);
        chk("R1", "end_col", int'(end_col), 0);
    endtask

    task automatic t_exact();
        // R2: identical short sequences, peak on the last row
        for (int k = 0; k < 8; k++) begin rd[k] = (k * 3 + 1) % 4; rf[k] = rd[k]; end
        run_job("R2", 8, 8, 10, 2, 4, 6, 1, 1'b0);
    endtask

    task automatic t_mixed();
        // R2: related sequences with substitutions and a shift
        for (int k = 0; k < 20; k++) rd[k] = (k * 5 + k / 3) % 4;
        for (int k = 0; k < 24; k++) rf[k] = (k < 2) ? 3 : rd[(k - 2) % 20];
        rf[7] = (rf[7] + 1) % 4; rf[15] = (rf[15] + 2) % 4;
        run_job("R2", 20, 24, 5, 1, 3, 4, 1, 1'b0);
    endtask

    task automatic t_two_pass();
        // R4: partial second pass and two full passes
        for (int k = 0; k < 64; k++) rd[k] = (k * 7 + k / 5) % 4;
        for (int k = 0; k < 64; k++) rf[k] = (k % 11 == 4) ? (rd[k] + 1) % 4 : rd[k];
        run_job("R4", 40, 50, 20, 1, 4, 6, 1, 1'b0);
        run_job("R4", 64, 64, 12, 2, 3, 5, 2, 1'b0);
    endtask

    task automatic t_skip();
        // R8: one-row second pass and single-column reference
        for (int k = 0; k < 33; k++) rd[k] = (k * 3 + k / 4) % 4;
        for (int k = 0; k < 20; k++) rf[k] = rd[k + 13];
        run_job("R8", 33, 20, 4, 3, 2, 3, 1, 1'b0);
        rf[0] = rd[31];
        run_job("R8", 32, 1, 2, 1, 1, 1, 1, 1'b0);
    endtask

    task automatic t_seed_edge();
        // R3: nothing beats the seed, borders decay from it
        for (int k = 0; k < 6; k++) begin rd[k] = 0; rf[k] = 3; end
        run_job("R3", 5, 6, 30, 1, 9, 5, 2, 1'b0);
    endtask

    task automatic t_ties();
        // R5: read AC against ACAC, equal peaks at (2,2) and (2,4)
        rd[0] = 0; rd[1] = 1;
        rf[0] = 0; rf[1] = 1; rf[2] = 0; rf[3] = 1;
        run_job("R5", 2, 4, 0, 1, 9, 9, 9, 1'b0);
    endtask

    task automatic t_zero_row();
        // R6: seed zero and no matches: last row empty
        for (int k = 0; k < 4; k++) begin rd[k] = 1; rf[k] = 2; end
        run_job("R6", 4, 4, 0, 1, 5, 2, 1, 1'b0);
    endtask

    task automatic t_disturb();
        // R9: restart and input changes while busy are ignored
        for (int k = 0; k < 36; k++) rd[k] = (k * 9 + 2) % 4;
        for (int k = 0; k < 30; k++) rf[k] = rd[k + 3];
        run_job("R9", 36, 30, 7, 2, 3, 4, 1, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_exact();
        t_mixed();
        t_two_pass();
        t_skip();
        t_seed_edge();
        t_ties();
        t_zero_row();
        t_disturb();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R7 watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule